// File: doc/BRIEF.md
# Timer Slave-Mode Controller

This block is an up-counting timer whose progress is steered by one selected trigger line. A three-bit mode code decides what a trigger does to the counter. It can clear the counter, gate the counter clock by level, start a stopped counter once, or act as the counter clock itself. The counter can also run freely from the internal clock. A small multiplexer picks the trigger line from several inputs. The chosen line is brought into the clock domain by a synchronizer and turned into a one-cycle rising-edge pulse.

The counter counts prescaled ticks up to an auto-reload limit, then returns to zero and raises a one-cycle update pulse. The prescaler divider is double-buffered: a written value only takes effect at the next update event. Each synchronized trigger edge is also driven out at once on a trigger output, so downstream timers can follow. An alignment bit holds back this timer's own reaction by one cycle, so that it acts in the same cycle as the timers it feeds.

Configuration uses simple write-strobe/data ports for the control byte, the counter-enable bit, the prescaler and the reload limit.

Top module: `tmr_slave_ctl`

## Requirements
- R1: The control byte resets to 0x00 and reads back as written, with bit 3 always 0. Bits 2:0 hold the mode code, bits 6:4 hold the trigger-input index, and bit 7 holds the alignment bit.
- R2: On each counter step, a count at or above the reload limit returns to 0 and any other count rises by 1. `upd_evt` is high for exactly the cycle in which the count shows the value 0 that a wrap or a clear has just produced.
- R3: The prescaler passes one step for every (divider+1) ticks. A written divider takes effect only at the next update event, and the prescaler phase restarts from zero at that event.
- R4: In mode code 0, and for the undefined codes 1 to 3, the counter ticks on every cycle while the enable is 1, and trigger activity has no effect.
- R5: In mode code 4, a trigger rising edge sets the count and the prescaler phase to 0 and produces an update event. With alignment off, the count reads 0 after the third rising clock edge following the input rise.
- R6: In mode code 5, the counter ticks only while the synchronized trigger level is high. A trigger that stays high for N cycles adds exactly N ticks, and a low trigger holds the count without clearing it.
- R7: In mode code 6, a trigger rising edge sets the enable bit without changing the count. A later low trigger does not stop the counter.
- R8: In mode code 7 with the enable set, each trigger rising edge produces exactly one tick.
- R9: Only `trig_in[index]` can act. An index of N_TRIG or more selects a constant low.
- R10: With the alignment bit set, every trigger action happens one cycle later than with the bit clear. `trg_out` is never delayed: it is high for one cycle, after the second rising clock edge following the input rise.
- R11: While the enable is 0, the count holds. The one exception is a mode-4 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| en_we | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | Enable bit write data |
| psc_we | input | 1 | Prescaler divider write strobe |
| psc_wdata | input | PSC_W | Prescaler divider (buffered) |
| arr_we | input | 1 | Reload limit write strobe |
| arr_wdata | input | CNT_W | Reload limit (takes effect at once) |
| trig_in | input | N_TRIG | Candidate trigger lines |
| cfg_q | output | 8 | Control byte readback |
| cnt_en_q | output | 1 | Enable bit readback |
| cnt_q | output | CNT_W | Counter value |
| upd_evt | output | 1 | One-cycle update event |
| trg_out | output | 1 | Undelayed trigger pulse for downstream timers |

## Verification
On every cycle, the assertions check these invariants:
- the count is 0 whenever the update pulse is high;
- the prescaler phase never exceeds its active divider;
- the count holds while the enable is low, and while a gated trigger is low;
- a trigger edge in start mode always sets the enable.

The bench scenarios cover what needs a history of stimulus:
- the exact clock-edge latency of a clear, and its one-cycle shift when alignment is on;
- the exact tick count of a gate window, and the tick count from trains of random external pulses;
- the deferred takeover of a new prescaler divider;
- trigger selection, and the undefined mode codes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int SEL_W  = 3;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_FREE  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CLEAR = 3'd4;
  localparam logic [MODE_W-1:0] MODE_GATE  = 3'd5;
  localparam logic [MODE_W-1:0] MODE_START = 3'd6;
  localparam logic [MODE_W-1:0] MODE_EXTCK = 3'd7;

  typedef struct packed {
    logic              align;
    logic [SEL_W-1:0]  sel;
    logic              rsvd;
    logic [MODE_W-1:0] mode;
  } ctl_t;

  localparam logic [7:0] CTL_MASK = 8'hF7;
endpackage

// File: rtl/tsc_trig_front.sv
module tsc_trig_front #(
  parameter int N_TRIG      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_TRIG-1:0]        trig_in,
  input  logic [tsc_pkg::SEL_W-1:0] sel,
  input  logic                     align,
  output logic                     trg_out,
  output logic                     act_rise,
  output logic                     act_level
);
  logic                   mux_bit;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   lvl, rise;
  logic                   rise_dq, lvl_dq;

  always_comb begin
    mux_bit = 1'b0;
    for (int i = 0; i < N_TRIG; i++) begin
      if (sel == i[tsc_pkg::SEL_W-1:0]) mux_bit = trig_in[i];
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], mux_bit};
    end else begin : g_single
      assign sync_d = mux_bit;
    end
  endgenerate

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      rise_dq <= 1'b0;
      lvl_dq  <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= lvl;
      rise_dq <= rise;
      lvl_dq  <= lvl;
    end
  end

  assign trg_out   = rise;
  assign act_rise  = align ? rise_dq : rise;
  assign act_level = align ? lvl_dq  : lvl;
endmodule

// File: rtl/tsc_prescaler.sv
module tsc_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             load,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             step
);
  localparam logic [PSC_W-1:0] P_ONE = 1;

  logic [PSC_W-1:0] phase_q, phase_d;
  logic [PSC_W-1:0] div_q, div_d;

  always_comb begin
    phase_d = phase_q;
    step    = 1'b0;
    if (clr) begin
      phase_d = '0;
    end else if (tick) begin
      if (phase_q >= div_q) begin
        phase_d = '0;
        step    = 1'b1;
      end else begin
        phase_d = phase_q + P_ONE;
      end
    end
    div_d = load ? psc_pre : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      div_q   <= '0;
    end else begin
      phase_q <= phase_d;
      div_q   <= div_d;
    end
  end

  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= div_q)
    else $error("prescaler phase above active divider");
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             upd_now,
  output logic             upd_evt
);
  localparam logic [CNT_W-1:0] C_ONE = 1;

  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap    = step && (cnt_q >= limit);
    upd_now = clr | wrap;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt_q + C_ONE;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      upd_evt <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      upd_evt <= upd_now;
    end
  end

  assert_upd_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> (cnt_q == '0))
    else $error("update pulse with nonzero count");
endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl #(
  parameter int N_TRIG      = 4,
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              en_we,
  input  logic              en_wdata,
  input  logic              psc_we,
  input  logic [PSC_W-1:0]  psc_wdata,
  input  logic              arr_we,
  input  logic [CNT_W-1:0]  arr_wdata,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [7:0]        cfg_q,
  output logic              cnt_en_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              upd_evt,
  output logic              trg_out
);
  import tsc_pkg::*;

  ctl_t             ctl_q, ctl_d;
  logic             en_d;
  logic [PSC_W-1:0] psc_pre_q, psc_pre_d;
  logic [CNT_W-1:0] arr_q, arr_d;
  logic             act_rise, act_level;
  logic             tick, clr_trig, step, upd_now;

  tsc_trig_front #(.N_TRIG(N_TRIG), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(ctl_q.sel),
    .align(ctl_q.align), .trg_out(trg_out), .act_rise(act_rise),
    .act_level(act_level)
  );

  always_comb begin
    clr_trig = (ctl_q.mode == MODE_CLEAR) && act_rise;
    case (ctl_q.mode)
      MODE_GATE:  tick = cnt_en_q & act_level;
      MODE_EXTCK: tick = cnt_en_q & act_rise;
      default:    tick = cnt_en_q;
    endcase
  end

  always_comb begin
    ctl_d     = cfg_we ? ctl_t'(cfg_wdata & CTL_MASK) : ctl_q;
    psc_pre_d = psc_we ? psc_wdata : psc_pre_q;
    arr_d     = arr_we ? arr_wdata : arr_q;
    if ((ctl_q.mode == MODE_START) && act_rise) en_d = 1'b1;
    else if (en_we)                             en_d = en_wdata;
    else                                        en_d = cnt_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      cnt_en_q  <= 1'b0;
      psc_pre_q <= '0;
      arr_q     <= '0;
    end else begin
      ctl_q     <= ctl_d;
      cnt_en_q  <= en_d;
      psc_pre_q <= psc_pre_d;
      arr_q     <= arr_d;
    end
  end

  tsc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_trig), .load(upd_now),
    .psc_pre(psc_pre_q), .step(step)
  );

  tsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(clr_trig), .limit(arr_q),
    .cnt_q(cnt_q), .upd_now(upd_now), .upd_evt(upd_evt)
  );

  assign cfg_q = ctl_q;

  assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_q && !clr_trig) |=> $stable(cnt_q))
    else $error("count moved while enable low");

  assert_gate_low_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q.mode == MODE_GATE) && !act_level) |=> $stable(cnt_q))
    else $error("count moved while gate low");

  assert_start_sets_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q.mode == MODE_START) && act_rise) |=> cnt_en_q)
    else $error("start edge did not set enable");
endmodule

// File: tb/sim_tmr_slave_ctl.sv
module sim_tmr_slave_ctl;
  localparam int NT = 4;
  localparam int CW = 16;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, en_we = 1'b0, en_wdata = 1'b0;
  logic          psc_we = 1'b0, arr_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [PW-1:0] psc_wdata = '0;
  logic [CW-1:0] arr_wdata = '0;
  logic [NT-1:0] trig_in = '0;
  logic [7:0]    cfg_q;
  logic          cnt_en_q, upd_evt, trg_out;
  logic [CW-1:0] cnt_q;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_slave_ctl #(.N_TRIG(NT), .CNT_W(CW), .PSC_W(PW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .en_we(en_we), .en_wdata(en_wdata), .psc_we(psc_we), .psc_wdata(psc_wdata),
    .arr_we(arr_we), .arr_wdata(arr_wdata), .trig_in(trig_in), .cfg_q(cfg_q),
    .cnt_en_q(cnt_en_q), .cnt_q(cnt_q), .upd_evt(upd_evt), .trg_out(trg_out)
  );

  function automatic logic [7:0] mkcfg(int mode, int sel, int align);
    return {align[0], sel[2:0], 1'b0, mode[2:0]};
  endfunction

  function automatic int exp_adv(int c0, int k, int lim);
    int c = c0;
    for (int i = 0; i < k; i++) c = (c >= lim) ? 0 : c + 1;
    return c;
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(logic [7:0] v);
    cfg_wdata = v; cfg_we = 1'b1; tick(1); cfg_we = 1'b0;
  endtask
  task automatic wr_en(logic v);
    en_wdata = v; en_we = 1'b1; tick(1); en_we = 1'b0;
  endtask
  task automatic wr_psc(int v);
    psc_wdata = v[PW-1:0]; psc_we = 1'b1; tick(1); psc_we = 1'b0;
  endtask
  task automatic wr_arr(int v);
    arr_wdata = v[CW-1:0]; arr_we = 1'b1; tick(1); arr_we = 1'b0;
  endtask
  task automatic pulse(int idx, int hi, int lo);
    trig_in[idx] = 1'b1; tick(hi);
    trig_in[idx] = 1'b0; tick(lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, n, k, hi, lo, lim;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 cfg reset", cfg_q, 0);
    chk("R1 enable reset", cnt_en_q, 0);
    chk("R2 count reset", cnt_q, 0);
    chk("R2 upd reset", upd_evt, 0);
    chk("R10 trg_out reset", trg_out, 0);

    // R4 free run, trigger ignored
    wr_arr(1000); wr_en(1'b1);
    c0 = cnt_q;
    for (int i = 0; i < 5; i++) pulse(0, 1, 1);
    chk("R4 free run with trigger noise", cnt_q, exp_adv(c0, 10, 1000));

    // R11 enable low holds
    wr_en(1'b0); c0 = cnt_q;
    for (int i = 0; i < 3; i++) pulse(0, 1, 1);
    chk("R11 hold while disabled", cnt_q, c0);
    wr_en(1'b1);

    // R2 wrap and update pulse
    wr_arr(5);
    for (int i = 0; i < 30 && cnt_q != 5; i++) tick(1);
    chk("R2 reached limit", cnt_q, 5);
    tick(1);
    chk("R2 wrap to zero", cnt_q, 0);
    chk("R2 update pulse", upd_evt, 1);
    tick(1);
    chk("R2 update one cycle", upd_evt, 0);
    chk("R2 count after wrap", cnt_q, 1);

    // R5 clear mode, no alignment
    wr_arr(1000); wr_cfg(mkcfg(4, 0, 0)); tick(5);
    trig_in[0] = 1'b1; tick(2);
    chk("R10 trg_out after second edge", trg_out, 1);
    chk("R5 not yet cleared", int'(cnt_q != 0), 1);
    tick(1);
    chk("R5 cleared on third edge", cnt_q, 0);
    chk("R5 update on clear", upd_evt, 1);
    chk("R10 trg_out single cycle", trg_out, 0);
    tick(1);
    chk("R5 counts on after clear", cnt_q, 1);
    trig_in[0] = 1'b0; tick(3);

    // R10 aligned clear
    wr_cfg(mkcfg(4, 0, 1)); tick(5);
    trig_in[0] = 1'b1; tick(2);
    chk("R10 trg_out undelayed", trg_out, 1);
    tick(1);
    chk("R10 clear held back", int'(cnt_q != 0), 1);
    tick(1);
    chk("R10 clear one cycle later", cnt_q, 0);
    chk("R10 update one cycle later", upd_evt, 1);
    trig_in[0] = 1'b0; tick(3);

    // R3 buffered divider
    wr_cfg(mkcfg(4, 0, 0));
    wr_psc(3); c0 = cnt_q; tick(8);
    chk("R3 divider not yet active", cnt_q, exp_adv(c0, 8, 1000));
    trig_in[0] = 1'b1; tick(3);
    chk("R3 clear loads divider", cnt_q, 0);
    tick(8);
    chk("R3 divide by four", cnt_q, 2);
    trig_in[0] = 1'b0; wr_psc(0); tick(2);
    trig_in[0] = 1'b1; tick(3);
    trig_in[0] = 1'b0; tick(3);
    c0 = cnt_q; tick(4);
    chk("R3 divider back to one", cnt_q, exp_adv(c0, 4, 1000));

    // R6 gated, random windows
    for (int it = 0; it < 4; it++) begin
      wr_cfg(mkcfg(5, 0, it % 2)); tick(4);
      c0 = cnt_q;
      n = 1 + ($urandom % 20);
      trig_in[0] = 1'b1; tick(n);
      trig_in[0] = 1'b0; tick(6);
      chk("R6 gate window ticks", cnt_q, exp_adv(c0, n, 1000));
      tick(5);
      chk("R6 hold when gate low", cnt_q, exp_adv(c0, n, 1000));
    end

    // R7 start mode
    wr_en(1'b0); wr_cfg(mkcfg(6, 0, 0)); tick(3);
    c0 = cnt_q;
    chk("R7 idle before start", cnt_en_q, 0);
    trig_in[0] = 1'b1; tick(3);
    chk("R7 start sets enable", cnt_en_q, 1);
    chk("R7 start keeps count", cnt_q, c0);
    tick(10);
    trig_in[0] = 1'b0; tick(10);
    chk("R7 low trigger does not stop", cnt_q, exp_adv(c0, 20, 1000));

    // R8 external clock, random trains, one with small limit
    wr_cfg(mkcfg(7, 0, 0)); tick(4);
    for (int it = 0; it < 4; it++) begin
      lim = (it == 2) ? 6 : 1000;
      wr_arr(lim); c0 = cnt_q;
      k = 3 + ($urandom % 10);
      for (int p = 0; p < k; p++) begin
        hi = 1 + ($urandom % 3); lo = 1 + ($urandom % 3);
        pulse(0, hi, lo);
      end
      tick(4);
      chk("R8 one tick per edge", cnt_q, exp_adv(c0, k, lim));
    end
    wr_arr(1000);

    // R9 trigger selection
    wr_cfg(mkcfg(7, 2, 0)); tick(4); c0 = cnt_q;
    for (int p = 0; p < 4; p++) pulse(0, 2, 2);
    chk("R9 unselected line ignored", cnt_q, c0);
    for (int p = 0; p < 4; p++) pulse(2, 2, 2);
    tick(4);
    chk("R9 selected line counts", cnt_q, exp_adv(c0, 4, 1000));
    wr_cfg(mkcfg(7, 5, 0)); tick(4); c0 = cnt_q;
    for (int p = 0; p < 3; p++) begin
      trig_in = '1; tick(2); trig_in = '0; tick(2);
    end
    chk("R9 out-of-range index is low", cnt_q, c0);

    // R4 undefined code acts as free run
    wr_cfg(mkcfg(2, 0, 0)); tick(2); c0 = cnt_q;
    for (int i = 0; i < 5; i++) pulse(0, 1, 1);
    chk("R4 undefined code free run", cnt_q, exp_adv(c0, 10, 1000));

    // R1 readback with reserved bit
    wr_cfg(8'hFF);
    chk("R1 readback masks bit 3", cfg_q, 8'hF7);
    wr_cfg(8'h00);
    chk("R1 readback zero", cfg_q, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule